// File: doc/BRIEF.md
# Always-On NMI Interrupt Controller

This block collects interrupt requests in an always-on domain and serves two consumers at once. One input is an external non-maskable interrupt pin. It passes through a programmable trigger decoder into a sticky pending latch. That latch, gated by its enable bit, drives an active-high level line toward the main interrupt distributor. The remaining inputs are sent to the distributor unchanged. They are also latched into the pending register, so that a companion coprocessor can see them.

The coprocessor receives one summary interrupt, which the enable, mask and response registers qualify. It also has a vector register. The vector register points at the lowest-numbered active source, relative to a programmable base address. All registers sit on a simple 32-bit register bus: a one-cycle write strobe, and a combinational read that follows the address.

Top module: `aon_irq_ctrl`

## Requirements
- R1: After reset the pending, enable, mask, response, base and trigger registers read 0. The NMI synchronizer rests at logic 1. dist_nmi and cop_irq are 0.
- R2: The trigger field at offset 0x0c holds bits [1:0]. Its codes are: 0 level low, 1 falling edge, 2 level high, 3 rising edge. The pin passes through a two-flop synchronizer, and an edge is judged against the synchronized value one cycle earlier. A pin change reaches pending bit 0 on the third rising clock edge. Pin activity that does not match the selected trigger leaves pending bit 0 clear.
- R3: Once pending bit 0 is set, it stays set after the trigger condition ends, until software clears it.
- R4: Writing 1 to a bit of the pending register (offset 0x10) clears that bit, and writing 0 leaves it unchanged. When a set and a clear meet in the same cycle, the set wins, so a level trigger that is still active keeps the bit set.
- R5: dist_nmi is high exactly when pending bit 0 and enable bit 0 (offset 0x40) are both 1.
- R6: dist_irq[i] equals irq_in[i] for every i from 1 up, whatever the enable register holds.
- R7: An irq_in[i] that is high at a rising clock edge sets pending bit i at that edge.
- R8: cop_irq is the OR over all bits of pending AND enable AND NOT mask (offset 0x50) AND NOT response (offset 0x60).
- R9: The vector register at offset 0x00 returns base + 4 × the index of the lowest bit set in pending AND enable AND NOT mask. When no such bit is set, it returns base alone. The base register at offset 0x04 always reads 0 in bits [1:0].
- R10: Reads from unmapped offsets return 0. Writes to unmapped offsets change no register. The trigger field reads back only its 2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| nmi_pin | input | 1 | Asynchronous NMI pin |
| irq_in | input | 31 | Synchronous interrupt inputs 1..31 |
| dist_nmi | output | 1 | Level-high NMI toward the distributor |
| dist_irq | output | 31 | Pass-through inputs toward the distributor |
| cop_irq | output | 1 | Qualified summary interrupt to the coprocessor |

## Verification
The assertions check four things on every cycle: the latch keeps pending bit 0 until a clear arrives, a set beats a clear that lands in the same cycle, an edge mode raises no event while the synchronized pin holds still, and the coprocessor summary never rises without a vector candidate. The bench scenarios cover what needs a stimulus sequence. That includes the decoding of each trigger code from pin waveforms, and the three-edge synchronizer latency. It also includes the vector address moving as mask bits change, the response bits silencing cop_irq, and the enable register leaving the distributor pass-through alone.

// File: rtl/aon_irq_pkg.sv
package aon_irq_pkg;

  localparam logic [7:0] OFF_VECTOR = 8'h00;
  localparam logic [7:0] OFF_BASE   = 8'h04;
  localparam logic [7:0] OFF_TRIG   = 8'h0c;
  localparam logic [7:0] OFF_PEND   = 8'h10;
  localparam logic [7:0] OFF_ENABLE = 8'h40;
  localparam logic [7:0] OFF_MASK   = 8'h50;
  localparam logic [7:0] OFF_RESP   = 8'h60;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_FALL   = 2'd1,
    TRIG_LVL_HI = 2'd2,
    TRIG_RISE   = 2'd3
  } trig_t;

  function automatic logic trig_hit(trig_t mode, logic cur, logic prev);
    case (mode)
      TRIG_LVL_LO: return !cur;
      TRIG_FALL:   return prev && !cur;
      TRIG_LVL_HI: return cur;
      default:     return !prev && cur;
    endcase
  endfunction

  function automatic logic [31:0] vec_addr(logic [31:0] base, logic [31:0] act);
    logic [31:0] res;
    res = base;
    for (int i = 31; i >= 0; i--) begin
      if (act[i]) res = base + (32'(i) << 2);
    end
    return res;
  endfunction

endpackage

// File: rtl/nmi_trigger.sv
module nmi_trigger
  import aon_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin,
  input  trig_t mode,
  output logic  evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic pin_s;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;

  assign evt = trig_hit(mode, pin_s, prev_q);

  // R2: an edge mode never fires while the synchronized pin is steady
  a_r2_edge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == TRIG_RISE || mode == TRIG_FALL) && $stable(pin_s)) |-> !evt);

endmodule

// File: rtl/pend_latch.sv
module pend_latch #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set_vec;

  // R3: NMI latch holds until software clears it
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !clr_vec[0]) |=> pend[0]);

  // R4: a set beats a simultaneous clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

  // R4: a lone clear takes effect on the next edge
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));

endmodule

// File: rtl/aon_reg_file.sv
module aon_reg_file
  import aon_irq_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [N-1:0]  pend,
  input  logic [31:0]   vector,
  output logic [31:0]   rdata,
  output logic [N-1:0]  enable,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  resp,
  output logic [31:0]   base,
  output trig_t         trig,
  output logic [N-1:0]  clr_vec
);
  function automatic logic [31:0] widen(logic [N-1:0] v);
    logic [31:0] r;
    r = '0;
    r[N-1:0] = v;
    return r;
  endfunction

  logic hit_en, hit_mask, hit_resp, hit_base, hit_trig, hit_pend;

  assign hit_en   = wr && (addr == AW'(OFF_ENABLE));
  assign hit_mask = wr && (addr == AW'(OFF_MASK));
  assign hit_resp = wr && (addr == AW'(OFF_RESP));
  assign hit_base = wr && (addr == AW'(OFF_BASE));
  assign hit_trig = wr && (addr == AW'(OFF_TRIG));
  assign hit_pend = wr && (addr == AW'(OFF_PEND));

  assign clr_vec = hit_pend ? wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      mask   <= '0;
      resp   <= '0;
      base   <= '0;
      trig   <= TRIG_LVL_LO;
    end else begin
      if (hit_en)   enable <= wdata[N-1:0];
      if (hit_mask) mask   <= wdata[N-1:0];
      if (hit_resp) resp   <= wdata[N-1:0];
      if (hit_base) base   <= {wdata[31:2], 2'b00};
      if (hit_trig) trig   <= trig_t'(wdata[1:0]);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(OFF_VECTOR): rdata = vector;
      AW'(OFF_BASE):   rdata = base;
      AW'(OFF_TRIG):   rdata = {30'd0, trig};
      AW'(OFF_PEND):   rdata = widen(pend);
      AW'(OFF_ENABLE): rdata = widen(enable);
      AW'(OFF_MASK):   rdata = widen(mask);
      AW'(OFF_RESP):   rdata = widen(resp);
      default:         rdata = '0;
    endcase
  end

  // R10: the trigger field moves only on a write
  a_r10_trig_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(trig));

endmodule

// File: rtl/aon_irq_ctrl.sv
module aon_irq_ctrl
  import aon_irq_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          nmi_pin,
  input  logic [N-1:1]  irq_in,
  output logic          dist_nmi,
  output logic [N-1:1]  dist_irq,
  output logic          cop_irq
);
  trig_t        trig;
  logic         nmi_evt;
  logic [N-1:0] set_vec, clr_vec, pend, enable, mask, resp;
  logic [N-1:0] vec_act;
  logic [31:0]  base, vector, act32;

  nmi_trigger #(.SYNC_STAGES(2)) u_trig (
    .clk(clk), .rst_n(rst_n), .pin(nmi_pin), .mode(trig), .evt(nmi_evt)
  );

  assign set_vec = {irq_in, nmi_evt};

  pend_latch #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend)
  );

  aon_reg_file #(.N(N), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pend(pend), .vector(vector), .rdata(bus_rdata), .enable(enable),
    .mask(mask), .resp(resp), .base(base), .trig(trig), .clr_vec(clr_vec)
  );

  assign vec_act = pend & enable & ~mask;

  always_comb begin
    act32 = '0;
    act32[N-1:0] = vec_act;
  end

  assign vector   = vec_addr(base, act32);
  assign cop_irq  = |(vec_act & ~resp);
  assign dist_nmi = pend[0] & enable[0];
  assign dist_irq = irq_in;

  // R8: the coprocessor summary implies a vector candidate exists
  a_r8_cop_vec: assert property (@(posedge clk) disable iff (!rst_n)
    cop_irq |-> (vector != base || vec_act[0]));

  // R5: a clear with no new event drops the distributor NMI
  a_r5_nmi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[0] && !nmi_evt) |=> !dist_nmi);

endmodule

// File: tb/tb_aon_irq_ctrl.sv
module tb_aon_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        nmi_pin = 1'b1;
  logic [31:1] irq_in = '0;
  logic        dist_nmi, cop_irq;
  logic [31:1] dist_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  aon_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_pin(nmi_pin),
    .irq_in(irq_in), .dist_nmi(dist_nmi), .dist_irq(dist_irq), .cop_irq(cop_irq)
  );

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (bus_rd && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (bus_rdata !== e.exp) begin
        n_bad++;
        $display("FAIL %s: read act=%h exp=%h", e.tag, bus_rdata, e.exp);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    @(posedge clk); #1;
    x.exp = e; x.tag = tag;
    sb.push_back(x);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, e);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    // R1 reset state
    chk("R1 dist_nmi", 32'(dist_nmi), 0);
    chk("R1 cop_irq", 32'(cop_irq), 0);
    rd(8'h10, 0, "R1 pending");
    rd(8'h40, 0, "R1 enable");
    rd(8'h00, 0, "R1 vector");
    rd(8'h0c, 0, "R1 trigger");

    // R10 trigger width and unmapped offsets
    wr(8'h0c, 32'hFF);
    rd(8'h0c, 3, "R10 trigger 2-bit");
    rd(8'h20, 0, "R10 unmapped read");

    // R2 rising edge mode (3)
    nmi_pin = 1'b0; cyc(4);
    rd(8'h10, 0, "R2 rise ignores fall");
    nmi_pin = 1'b1; cyc(4);
    rd(8'h10, 1, "R2 rise latched");
    chk("R5 nmi gated by enable", 32'(dist_nmi), 0);
    wr(8'h40, 1);
    chk("R5 nmi out", 32'(dist_nmi), 1);
    chk("R8 cop from nmi", 32'(cop_irq), 1);
    rd(8'h00, 0, "R9 vector idx0");
    nmi_pin = 1'b0; cyc(4);
    rd(8'h10, 1, "R3 hold after condition");
    wr(8'h10, 0);
    rd(8'h10, 1, "R4 write zero no effect");
    wr(8'h10, 1);
    rd(8'h10, 0, "R4 w1c");
    chk("R5 nmi dropped", 32'(dist_nmi), 0);

    // R2 falling edge mode (1)
    wr(8'h0c, 1);
    nmi_pin = 1'b1; cyc(4);
    rd(8'h10, 0, "R2 fall ignores rise");
    nmi_pin = 1'b0; cyc(4);
    rd(8'h10, 1, "R2 fall latched");
    wr(8'h10, 1);
    rd(8'h10, 0, "R4 clear fall");

    // R2 level high mode (2), set wins over clear
    wr(8'h0c, 2);
    rd(8'h10, 0, "R2 lvl hi idle");
    nmi_pin = 1'b1; cyc(4);
    rd(8'h10, 1, "R2 lvl hi latched");
    wr(8'h10, 1);
    rd(8'h10, 1, "R4 level still active resets");
    nmi_pin = 1'b0; cyc(4);
    wr(8'h10, 1);
    rd(8'h10, 0, "R4 clear after level gone");

    // R2 level low mode (0)
    wr(8'h0c, 0);
    cyc(2);
    rd(8'h10, 1, "R2 lvl lo latched");
    nmi_pin = 1'b1; cyc(4);
    wr(8'h10, 1);
    rd(8'h10, 0, "R2 lvl lo cleared");
    wr(8'h0c, 3);
    wr(8'h40, 0);

    // R6 pass-through and R7 latching
    irq_in = 31'h2AAA_5555;
    cyc(1);
    chk("R6 passthru enable off", 32'(dist_irq), 32'h2AAA_5555);
    rd(8'h10, {31'h2AAA_5555, 1'b0}, "R7 inputs latched");
    wr(8'h40, 32'hFFFF_FFFF);
    irq_in = 31'h1234_5678;
    cyc(1);
    chk("R6 passthru enable on", 32'(dist_irq), 32'h1234_5678);
    irq_in = '0;
    wr(8'h40, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 0, "R4 clear all");

    // R9 vector, R8 mask and response
    wr(8'h04, 32'h0000_1003);
    rd(8'h04, 32'h0000_1000, "R9 base aligned");
    rd(8'h00, 32'h0000_1000, "R9 vector empty");
    wr(8'h40, 32'h0000_0220);
    irq_in[5] = 1'b1; irq_in[9] = 1'b1;
    cyc(1);
    irq_in = '0;
    rd(8'h10, 32'h0000_0220, "R7 pulse latched");
    chk("R8 cop set", 32'(cop_irq), 1);
    rd(8'h00, 32'h0000_1014, "R9 vector idx5");
    wr(8'h50, 32'h0000_0020);
    rd(8'h00, 32'h0000_1024, "R9 vector idx9 after mask");
    chk("R8 cop with idx9", 32'(cop_irq), 1);
    wr(8'h60, 32'h0000_0200);
    chk("R8 resp silences cop", 32'(cop_irq), 0);
    rd(8'h00, 32'h0000_1024, "R9 vector ignores resp");
    wr(8'h50, 32'h0000_0220);
    rd(8'h00, 32'h0000_1000, "R9 vector all masked");
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0000_0220, "R10 unmapped write ignored");

    cyc(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule